// File: doc/BRIEF.md
# Fuse Byte Read Sequencer

This block reads a run of consecutive bytes out of a one-time-programmable fuse macro by driving the macro's control pins through a timed read protocol. A host pulses a start input together with a 10-bit start byte address and a byte count. While the run is in progress the block reports busy. It opens a read session, then steps through the addresses one byte at a time. For each byte it presents the address, raises the strobe, samples the macro's 8-bit data output while the strobe is still high, and drops the strobe. Each step waits for a settle interval of about one microsecond.

Every byte read comes back on `rd_data` with a one-cycle `rd_valid` qualifier, in ascending address order. When the run ends, the macro is put back into standby and a one-cycle `done` pulse is given. The settle interval is a cycle count. By default it is derived from the clock frequency and a settle time in nanoseconds. With the defaults (250 MHz, 1000 ns) it is 250 cycles, written D below.

Top module: `fuse_rd_seq`

## Requirements
- R1: The macro is driven through a 16-bit control word `fuse_ctrl`. Bit 0 is chip-select-bar, bit 1 is strobe, bit 2 is load, bit 3 is program-enable-bar, and bits 15:6 carry the byte address. Bits 5:4 are always 0.
- R2: From reset and whenever the block is idle, `fuse_ctrl` equals 0x0009 (standby: program-enable-bar and chip-select-bar high), and `busy`, `rd_valid` and `done` are low.
- R3: A start with a nonzero count opens a session. For the D cycles following the accepting edge, `fuse_ctrl` equals 0x000C (load and program-enable-bar high, address 0).
- R4: Each byte occupies 3D+1 cycles, with the control word in this order. First, one cycle of 0x000C with the address field cleared. Then D cycles of 0x000C with the address in bits 15:6. Then D cycles of the same value with strobe also high. Then D cycles with strobe low and the address still driven.
- R5: The data byte is sampled on the last strobe-high cycle of a byte. `rd_valid` is high for exactly one cycle: the first cycle after strobe falls. In that cycle `rd_data` holds the macro output for that byte's address.
- R6: The address starts at the requested value and increases by one per byte, modulo 1024: after 1023 comes 0.
- R7: In the cycle after the last byte's final settle cycle, `fuse_ctrl` returns to 0x0009 and `done` is high for that one cycle. From the next cycle on, `busy` is low.
- R8: A start with a count of zero gives `done` in the cycle right after the accepting edge. The strobe is never raised and `fuse_ctrl` stays 0x0009.
- R9: A start pulse while `busy` is high is ignored: the ongoing run's pin sequence, data and completion time are unchanged.
- R10: `busy` is high from the cycle after an accepted start through the `done` cycle inclusive.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_start | input | 1 | Start pulse, accepted only when idle |
| req_addr | input | 10 | First byte address |
| req_len | input | LEN_W (11) | Number of bytes to read |
| busy | output | 1 | Run in progress |
| rd_valid | output | 1 | One-cycle qualifier for `rd_data` |
| rd_data | output | 8 | Byte read from the macro |
| done | output | 1 | One-cycle end-of-run pulse |
| fuse_ctrl | output | 16 | Control pins and address to the macro |
| fuse_dout | input | 8 | Data output of the macro |

## Verification
Cycle 0 is the cycle right after the clock edge that accepts a start.

| Result | Due in cycle |
|---|---|
| Session open | cycles 0 to D-1 |
| Byte k, address-clear cycle | D + k(3D+1) |
| Byte k, `rd_valid` | (k+1)(3D+1) |
| `done` for a count n | D + n(3D+1) |
| `done` for a zero count | 0 |

The bench counts cycles from the accepting edge and samples at every falling edge. It compares the control word, `rd_valid`/`rd_data`, `done` and `busy` with values rebuilt from these formulas in every cycle of the run and a few cycles past it. A shift of even one cycle in any phase is therefore reported.

// File: rtl/fuse_rd_pkg.sv
package fuse_rd_pkg;

  localparam int FUSE_AW   = 10;
  localparam int FUSE_DW   = 8;
  localparam int CTRL_W    = 16;

  localparam int BIT_CSB   = 0;
  localparam int BIT_STRB  = 1;
  localparam int BIT_LOAD  = 2;
  localparam int BIT_PGENB = 3;
  localparam int ADDR_LSB  = 6;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_OPEN,
    PH_ACLR,
    PH_ADDR,
    PH_STRB,
    PH_HOLD,
    PH_DONE
  } phase_t;

  // settle interval in cycles, rounded up, never below one
  function automatic int settle_cycles(input int clk_mhz, input int settle_ns);
    int c;
    c = (clk_mhz * settle_ns + 999) / 1000;
    return (c < 1) ? 1 : c;
  endfunction

  function automatic logic [FUSE_AW-1:0] addr_next(input logic [FUSE_AW-1:0] a);
    return a + 1'b1;
  endfunction

  function automatic logic [CTRL_W-1:0] standby_word();
    logic [CTRL_W-1:0] w;
    w = '0;
    w[BIT_PGENB] = 1'b1;
    w[BIT_CSB]   = 1'b1;
    return w;
  endfunction

  function automatic logic [CTRL_W-1:0] ctrl_word(input phase_t ph,
                                                  input logic [FUSE_AW-1:0] a);
    logic [CTRL_W-1:0] w;
    w = '0;
    case (ph)
      PH_OPEN, PH_ACLR: begin
        w[BIT_LOAD]  = 1'b1;
        w[BIT_PGENB] = 1'b1;
      end
      PH_ADDR, PH_HOLD: begin
        w[BIT_LOAD]  = 1'b1;
        w[BIT_PGENB] = 1'b1;
        w[ADDR_LSB +: FUSE_AW] = a;
      end
      PH_STRB: begin
        w[BIT_LOAD]  = 1'b1;
        w[BIT_PGENB] = 1'b1;
        w[BIT_STRB]  = 1'b1;
        w[ADDR_LSB +: FUSE_AW] = a;
      end
      default: w = standby_word();
    endcase
    return w;
  endfunction

endpackage

// File: rtl/fuse_rd_timer.sv
module fuse_rd_timer #(
  parameter int DELAY_CYCLES = 250
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  output logic tick
);
  localparam int CW = (DELAY_CYCLES > 1) ? $clog2(DELAY_CYCLES) : 1;
  localparam logic [CW-1:0] LOADV = CW'(DELAY_CYCLES - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (!rst_n)             cnt_q <= LOADV;
    else if (restart)       cnt_q <= LOADV;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign tick = (cnt_q == '0);

  AST_SETTLE_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!tick || DELAY_CYCLES == 1)); // R4

endmodule

// File: rtl/fuse_rd_fsm.sv
module fuse_rd_fsm
  import fuse_rd_pkg::*;
#(
  parameter int LEN_W = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_start,
  input  logic [FUSE_AW-1:0] req_addr,
  input  logic [LEN_W-1:0]   req_len,
  input  logic               tick,
  output phase_t             phase,
  output logic               phase_chg,
  output logic [FUSE_AW-1:0] addr_q,
  output logic               sample_evt
);
  phase_t             ph_n;
  logic [LEN_W-1:0]   rem_q;
  logic               accept_evt;
  logic               advance_evt;
  logic               last_byte;

  assign accept_evt  = (phase == PH_IDLE) && req_start;
  assign sample_evt  = (phase == PH_STRB) && tick;
  assign advance_evt = (phase == PH_HOLD) && tick;
  assign last_byte   = (rem_q == LEN_W'(1));

  always_comb begin
    ph_n = phase;
    case (phase)
      PH_IDLE: if (req_start) ph_n = (req_len == '0) ? PH_DONE : PH_OPEN;
      PH_OPEN: if (tick) ph_n = PH_ACLR;
      PH_ACLR: ph_n = PH_ADDR;
      PH_ADDR: if (tick) ph_n = PH_STRB;
      PH_STRB: if (tick) ph_n = PH_HOLD;
      PH_HOLD: if (tick) ph_n = last_byte ? PH_DONE : PH_ACLR;
      PH_DONE: ph_n = PH_IDLE;
      default: ph_n = PH_IDLE;
    endcase
  end

  assign phase_chg = (ph_n != phase);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      phase  <= PH_IDLE;
      addr_q <= '0;
      rem_q  <= '0;
    end else begin
      phase <= ph_n;
      if (accept_evt) begin
        addr_q <= req_addr;
        rem_q  <= req_len;
      end else if (advance_evt) begin
        addr_q <= addr_next(addr_q);
        rem_q  <= rem_q - 1'b1;
      end
    end
  end

  AST_BUSY_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (phase inside {PH_OPEN, PH_ADDR, PH_STRB} && req_start)
      |=> ($stable(addr_q) && $stable(rem_q))); // R9

  AST_ZERO_LEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    (accept_evt && req_len == '0) |=> (phase == PH_DONE)); // R8

endmodule

// File: rtl/fuse_rd_capture.sv
module fuse_rd_capture #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          sample,
  input  logic [DW-1:0] din,
  output logic          valid,
  output logic [DW-1:0] data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      valid <= 1'b0;
      data  <= '0;
    end else begin
      valid <= sample;
      if (sample) data <= din;
    end
  end
endmodule

// File: rtl/fuse_rd_seq.sv
module fuse_rd_seq
  import fuse_rd_pkg::*;
#(
  parameter int CLK_MHZ      = 250,
  parameter int SETTLE_NS    = 1000,
  parameter int DELAY_CYCLES = settle_cycles(CLK_MHZ, SETTLE_NS),
  parameter int LEN_W        = 11
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               req_start,
  input  logic [FUSE_AW-1:0] req_addr,
  input  logic [LEN_W-1:0]   req_len,
  output logic               busy,
  output logic               rd_valid,
  output logic [FUSE_DW-1:0] rd_data,
  output logic               done,
  output logic [CTRL_W-1:0]  fuse_ctrl,
  input  logic [FUSE_DW-1:0] fuse_dout
);
  phase_t             phase;
  logic               phase_chg;
  logic               tick;
  logic [FUSE_AW-1:0] addr_q;
  logic               sample_evt;

  fuse_rd_timer #(.DELAY_CYCLES(DELAY_CYCLES)) u_timer (
    .clk     (clk),
    .rst_n   (rst_n),
    .restart (phase_chg),
    .tick    (tick)
  );

  fuse_rd_fsm #(.LEN_W(LEN_W)) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_start  (req_start),
    .req_addr   (req_addr),
    .req_len    (req_len),
    .tick       (tick),
    .phase      (phase),
    .phase_chg  (phase_chg),
    .addr_q     (addr_q),
    .sample_evt (sample_evt)
  );

  fuse_rd_capture #(.DW(FUSE_DW)) u_cap (
    .clk    (clk),
    .rst_n  (rst_n),
    .sample (sample_evt),
    .din    (fuse_dout),
    .valid  (rd_valid),
    .data   (rd_data)
  );

  assign fuse_ctrl = ctrl_word(phase, addr_q);
  assign busy      = (phase != PH_IDLE);
  assign done      = (phase == PH_DONE);

  AST_SAMPLE_UNDER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> ($past(fuse_ctrl[BIT_STRB]) && !fuse_ctrl[BIT_STRB])); // R5

  AST_STROBE_HOLDS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (fuse_ctrl[BIT_STRB] && $past(fuse_ctrl[BIT_STRB]))
      |-> $stable(fuse_ctrl[ADDR_LSB +: FUSE_AW])); // R4

  AST_DONE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fuse_ctrl == standby_word())); // R7

  AST_ONE_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rd_valid, done})); // R7

  AST_IDLE_STANDBY: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (fuse_ctrl == standby_word() && !rd_valid)); // R2

endmodule

// File: tb/sim_fuse_rd_seq.sv
`timescale 1ns/1ps
module sim_fuse_rd_seq;
  localparam int D     = 250;
  localparam int P     = 3 * D + 1;
  localparam int LEN_W = 11;
  localparam logic [15:0] C_SBY  = 16'h0009;
  localparam logic [15:0] C_OPEN = 16'h000C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_start = 1'b0;
  logic [9:0]  req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic        busy, rd_valid, done;
  logic [7:0]  rd_data;
  logic [15:0] fuse_ctrl;
  logic [7:0]  fuse_dout;

  int tests = 0;
  int fails = 0;

  always #2 clk = ~clk;

  fuse_rd_seq u0 (
    .clk(clk), .rst_n(rst_n), .req_start(req_start), .req_addr(req_addr),
    .req_len(req_len), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data),
    .done(done), .fuse_ctrl(fuse_ctrl), .fuse_dout(fuse_dout)
  );

  // behavioural fuse array: content is a hash of the address, visible only under strobe
  function automatic logic [7:0] fuse_byte(input logic [9:0] a);
    int v;
    v = (int'(a) * 37 + 11) ^ (int'(a) >> 3);
    return v[7:0];
  endfunction

  assign fuse_dout = fuse_ctrl[1] ? fuse_byte(fuse_ctrl[15:6]) : 8'h00;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // R1 R2: reset state
  task automatic t_reset();
    check(fuse_ctrl == C_SBY && !busy && !rd_valid && !done, "R1 R2",
          "reset pins/flags", {busy, rd_valid, done, 13'd0, fuse_ctrl}, {16'd0, C_SBY});
  endtask

  // one request, checked cycle by cycle against the timing formulas (R3..R10)
  task automatic run_req(input logic [9:0] a, input int n, input bit poke, input string tag);
    int end_i, limit, vcnt;
    int e_ctrl, e_val, e_done, e_busy;
    logic [31:0] a_ctrl, x_ctrl, a_val, x_val, a_done, x_done, a_busy, x_busy;
    e_ctrl = 0; e_val = 0; e_done = 0; e_busy = 0; vcnt = 0;
    a_ctrl = 0; x_ctrl = 0; a_val = 0; x_val = 0;
    a_done = 0; x_done = 0; a_busy = 0; x_busy = 0;
    end_i = (n == 0) ? 0 : D + n * P;
    limit = end_i + 3;
    @(negedge clk);
    req_start = 1'b1; req_addr = a; req_len = LEN_W'(n);
    @(negedge clk);
    req_start = 1'b0;
    for (int i = 0; i <= limit; i++) begin
      logic [15:0] xc;
      logic xv, xd, xb;
      logic [7:0] xdat;
      xv = 1'b0; xd = 1'b0; xdat = 8'h00;
      if (poke && i == D + 5) begin
        req_start = 1'b1; req_addr = 10'h3FF; req_len = LEN_W'(1);   // R9 stimulus
      end else begin
        req_start = 1'b0;
      end
      if (i < end_i && i < D) begin
        xc = C_OPEN; xb = 1'b1;                                       // R3
      end else if (i < end_i) begin
        int j, b, r;
        logic [9:0] ad;
        j = i - D; b = j / P; r = j % P;
        ad = 10'((int'(a) + b) % 1024);                                // R6
        xb = 1'b1;
        if (r == 0)          xc = C_OPEN;                              // R4
        else if (r <= D)     xc = C_OPEN | {ad, 6'd0};
        else if (r <= 2 * D) xc = C_OPEN | {ad, 6'd0} | 16'h0002;
        else                 xc = C_OPEN | {ad, 6'd0};
        if (r == 2 * D + 1) begin xv = 1'b1; xdat = fuse_byte(ad); end // R5
      end else if (i == end_i) begin
        xc = C_SBY; xd = 1'b1; xb = 1'b1;                              // R7 R8
      end else begin
        xc = C_SBY; xb = 1'b0;                                         // R10
      end
      if (fuse_ctrl != xc && e_ctrl == 0) begin a_ctrl = fuse_ctrl; x_ctrl = xc; end
      if (fuse_ctrl != xc) e_ctrl++;
      if ((rd_valid != xv || (xv && rd_data != xdat)) && e_val == 0) begin
        a_val = {rd_valid, rd_data}; x_val = {xv, xdat};
      end
      if (rd_valid != xv || (xv && rd_data != xdat)) e_val++;
      if (rd_valid) vcnt++;
      if (done != xd && e_done == 0) begin a_done = i; x_done = end_i; end
      if (done != xd) e_done++;
      if (busy != xb && e_busy == 0) begin a_busy = i; x_busy = xb; end
      if (busy != xb) e_busy++;
      @(negedge clk);
    end
    req_start = 1'b0;
    check(e_ctrl == 0, (n == 0) ? "R8" : (poke ? "R9 R4" : "R3 R4 R6"),
          {tag, " ctrl word"}, a_ctrl, x_ctrl);
    check(e_val == 0 && vcnt == n, poke ? "R9 R5" : "R5",
          {tag, " valid/data"}, (e_val == 0) ? 32'(vcnt) : a_val, (e_val == 0) ? 32'(n) : x_val);
    check(e_done == 0, (n == 0) ? "R8" : "R7", {tag, " done cycle"}, a_done, x_done);
    check(e_busy == 0, "R10", {tag, " busy window"}, a_busy, x_busy);
  endtask

  initial begin
    #(4 * 150000);
    fails++; tests++;
    $display("FAIL R10 watchdog: actual %0d expected %0d", 1, 0);
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    run_req(10'd5,   1, 1'b0, "single");
    run_req(10'h100, 4, 1'b0, "four");
    run_req(10'd1022, 4, 1'b0, "wrap");           // R6 wrap 1023 -> 0
    run_req(10'd77,  0, 1'b0, "zero");            // R8
    run_req(10'd300, 2, 1'b1, "busy-start");      // R9
    run_req(10'd9,   1, 1'b0, "b2b-a");
    run_req(10'd10,  1, 1'b0, "b2b-b");
    t_reset();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule